// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a single-channel serial DAC. A host sends frames over three wires: an active-low frame strobe, a serial clock and serial data. The receiver oversamples all three in the system clock domain through two-stage synchronizers. It shifts one data bit on each falling serial clock edge while the strobe is low. When a complete frame has arrived, it loads a conversion code register and a two-bit power-down mode register.

Each frame has a fixed length set by a parameter, 16 or 24 bits. The two mode bits come first and the code follows MSB first. The receiver discards a frame that the strobe cuts short. A frame of all ones is a software reset: it returns the code and the mode to their power-on state, and an early strobe rise cannot abort it once it has begun. Each change of the code or the mode is announced by a strobe one system clock wide.

Top module: `dac_serial_front`

## Requirements
- R1: A frame is FRAME_W bits long, sent MSB first. Bit FRAME_W-1 is mode bit 1 and bit FRAME_W-2 is mode bit 0. The remaining FRAME_W-2 bits form the code, and its MSB is sent right after the mode bits.
- R2: Bits are sampled on falling serial clock edges while the strobe is low. Code and mode are loaded after the FRAME_W-th falling edge of the frame.
- R3: `update_o` is high for exactly one system clock for each accepted frame or software reset, and never otherwise.
- R4: If the strobe rises before the FRAME_W-th falling edge, the frame is discarded: code and mode are unchanged and no update pulse is produced. The exception is the case in R9.
- R5: A discarded frame leaves no residue: the next full frame loads exactly its own bits.
- R6: Falling edges after the FRAME_W-th one in a frame are ignored. They have no effect until the strobe goes high and then low again.
- R7: After reset, the code is midscale (only the code MSB set) when MIDSCALE=1, and zero otherwise. The mode is normal (00).
- R8: A full frame of all ones is a software reset. It sets the code to the R7 value and the mode to 00, and it pulses `update_o`.
- R9: If the strobe rises early after two or more bits have arrived and every bit so far was 1, the frame is still executed as a software reset, as in R8.
- R10: The mode encoding is 00 normal, 01 output grounded through a resistor, and 10 output three-state. A full frame with mode 11 that is not all ones is discarded. `pd_mode_o` never shows 11.
- R11: `code_o` and `pd_mode_o` change only in the cycle in which `update_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Active-low frame strobe |
| sclk_i | input | 1 | Serial clock; bits are sampled on its falling edges |
| sdin_i | input | 1 | Serial data |
| code_o | output | FRAME_W-2 | Current conversion code |
| pd_mode_o | output | 2 | Power-down mode: 00 normal, 01 grounded, 10 three-state |
| update_o | output | 1 | One-cycle pulse when the code or the mode is written |

## Verification
A corrupt bit counter or shift register shows at the ports within a few system clocks after a frame ends. The symptoms are a code shifted by one bit, mode bits swapped into the code, a missing update pulse, or a spurious one. A wrong ones-tracking flag shows at the ports as follows. It either turns a mode-11 or aborted frame into a reset, or fails to reset on an interrupted all-ones frame. Either way, `code_o` differs from the expected value right after the strobe rises. Because every output is registered and sampled about ten clocks after each frame, each fault is tied to the frame that exposed it.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_GND    = 2'b01,
    PD_TRI    = 2'b10,
    PD_RSVD   = 2'b11
  } pd_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_fe_shifter.sv
module dac_fe_shifter #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_fall_i,
  input  logic               sync_rise_i,
  input  logic               sync_lvl_i,
  input  logic               sclk_fall_i,
  input  logic               sdin_i,
  output logic               load_o,
  output logic               swrst_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               active_q, ones_q, load_q, swrst_q;
  logic               rst_cmd_armed;

  // all bits so far ones and both mode bits in: reset cannot be aborted
  assign rst_cmd_armed = ones_q && (cnt_q >= CNT_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      ones_q   <= 1'b0;
      load_q   <= 1'b0;
      swrst_q  <= 1'b0;
    end else begin
      load_q  <= 1'b0;
      swrst_q <= 1'b0;
      if (sync_fall_i) begin
        shreg_q  <= '0;
        cnt_q    <= '0;
        active_q <= 1'b1;
        ones_q   <= 1'b1;
      end else if (active_q) begin
        if (sync_rise_i) begin
          active_q <= 1'b0;
          shreg_q  <= '0;
          cnt_q    <= '0;
          if (rst_cmd_armed) swrst_q <= 1'b1;
        end else if (sclk_fall_i && !sync_lvl_i) begin
          shreg_q <= {shreg_q[FRAME_W-2:0], sdin_i};
          cnt_q   <= cnt_q + CNT_W'(1);
          ones_q  <= ones_q & sdin_i;
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            active_q <= 1'b0;
            if (ones_q && sdin_i) swrst_q <= 1'b1;
            else load_q <= 1'b1;
          end
        end
      end
    end
  end

  assign load_o  = load_q;
  assign swrst_o = swrst_q;
  assign frame_o = shreg_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W));

  // R4
  abort_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && sync_rise_i && !sync_fall_i && !rst_cmd_armed) |=> (!load_q && !swrst_q));

  // R6
  idle_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !sync_fall_i) |=> !load_q);
endmodule

// File: rtl/dac_fe_outreg.sv
module dac_fe_outreg
  import dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W   = 14,
  parameter bit          MIDSCALE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              swrst_i,
  input  logic [DATA_W+1:0] frame_i,
  output logic [DATA_W-1:0] code_o,
  output pd_mode_e          mode_o,
  output logic              update_o
);
  localparam logic [DATA_W-1:0] RST_CODE =
    MIDSCALE ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  logic [DATA_W-1:0] code_q;
  pd_mode_e          mode_q, frame_mode;
  logic              update_q;

  assign frame_mode = pd_mode_e'(frame_i[DATA_W+1:DATA_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= RST_CODE;
      mode_q   <= PD_NORMAL;
      update_q <= 1'b0;
    end else begin
      update_q <= 1'b0;
      if (swrst_i) begin
        code_q   <= RST_CODE;
        mode_q   <= PD_NORMAL;
        update_q <= 1'b1;
      end else if (load_i && frame_mode != PD_RSVD) begin
        code_q   <= frame_i[DATA_W-1:0];
        mode_q   <= frame_mode;
        update_q <= 1'b1;
      end
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign update_o = update_q;

  // R3
  update_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_q |=> !update_q);

  // R10
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != PD_RSVD);

  // R11
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> update_q);

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> update_q);
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_fe_pkg::*;
#(
  parameter int unsigned FRAME_W  = 16,
  parameter bit          MIDSCALE = 1'b1,
  localparam int unsigned DATA_W  = FRAME_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic [DATA_W-1:0] code_o,
  output logic [1:0]        pd_mode_o,
  output logic              update_o
);
  logic [2:0]         pins_s;
  logic               sync_s, sclk_s, sdin_s;
  logic               sync_d, sclk_d;
  logic               sync_fall, sync_rise, sclk_fall;
  logic               load, swrst;
  logic [FRAME_W-1:0] frame;
  pd_mode_e           mode;

  dac_fe_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sync_i, sclk_i, sdin_i}),
    .q_o    (pins_s)
  );

  assign {sync_s, sclk_s, sdin_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      sync_d <= sync_s;
      sclk_d <= sclk_s;
    end
  end

  assign sync_fall = sync_d & ~sync_s;
  assign sync_rise = ~sync_d & sync_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  dac_fe_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_fall_i (sync_fall),
    .sync_rise_i (sync_rise),
    .sync_lvl_i  (sync_s),
    .sclk_fall_i (sclk_fall),
    .sdin_i      (sdin_s),
    .load_o      (load),
    .swrst_o     (swrst),
    .frame_o     (frame)
  );

  dac_fe_outreg #(.DATA_W(DATA_W), .MIDSCALE(MIDSCALE)) i_outreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .swrst_i  (swrst),
    .frame_i  (frame),
    .code_o   (code_o),
    .mode_o   (mode),
    .update_o (update_o)
  );

  assign pd_mode_o = mode;
endmodule

// File: tb/test_dac_serial_front.sv
module test_dac_serial_front;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned FW = 16;
  localparam int unsigned DW = FW - 2;
  localparam logic [DW-1:0] RST_CODE = 14'h2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [DW-1:0] code;
  logic [1:0]    mode;
  logic          upd;

  int n_checks = 0, n_fail = 0, upd_cnt = 0;
  logic [DW-1:0] exp_code;
  logic [1:0]    exp_mode;
  int            exp_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_front #(.FRAME_W(FW), .MIDSCALE(1'b1)) i_dac_serial_front (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sclk_i(sclk), .sdin_i(sdin),
    .code_o(code), .pd_mode_o(mode), .update_o(upd)
  );

  always @(negedge clk) if (upd) upd_cnt <= upd_cnt + 1;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " code"}, 32'(code), 32'(exp_code));
    chk({req, " mode"}, 32'(mode), 32'(exp_mode));
    chk({req, " updates"}, 32'(upd_cnt), 32'(exp_upd));
  endtask

  // edges beyond FW send ones
  task automatic send(input logic [FW-1:0] w, input int edges);
    sync = 1'b0;
    wait_clk(4);
    for (int i = 0; i < edges; i++) begin
      sdin = (i < FW) ? w[FW-1-i] : 1'b1;
      wait_clk(2);
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(2);
    end
    sync = 1'b1;
    wait_clk(10);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    exp_code = RST_CODE; exp_mode = 2'b00; exp_upd = 0;
    check_state("R7 reset");

    // R1 R2 R3 R10: sweep of legal modes and codes
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [DW-1:0] d;
        d = (k == 0) ? '0 : (k == 15) ? '1 :
            DW'((k * 32'h1357 + m * 32'h0AB1) ^ (k << 3));
        send({2'(m), d}, FW);
        exp_code = d; exp_mode = 2'(m); exp_upd++;
        check_state("R1 R2 R3 R10 frame");
      end
    end

    // R4: aborts after 1, 8, 15 edges
    send({2'b01, 14'h1555}, 1);
    check_state("R4 abort 1");
    send({2'b01, 14'h1555}, 8);
    check_state("R4 abort 8");
    send({2'b10, 14'h2AAA}, 15);
    check_state("R4 abort 15");
    send({2'b11, 14'h0FFF}, 15);
    check_state("R4 R9 abort ones broken");
    send(16'hFFFF, 1);
    check_state("R4 R9 abort single one");

    // R5
    send({2'b10, 14'h2AAA}, FW);
    exp_code = 14'h2AAA; exp_mode = 2'b10; exp_upd++;
    check_state("R5 after abort");

    // R6: trailing edges
    send({2'b01, 14'h0123}, FW + 5);
    exp_code = 14'h0123; exp_mode = 2'b01; exp_upd++;
    check_state("R6 trailing edges");

    // R10: mode 11 not all ones discarded
    send({2'b11, 14'h1234}, FW);
    check_state("R10 mode 11 discarded");

    // R8: full software reset
    send(16'hFFFF, FW);
    exp_code = RST_CODE; exp_mode = 2'b00; exp_upd++;
    check_state("R8 software reset");

    // R9: interrupted reset after 5 and after 2 ones
    send({2'b01, 14'h0042}, FW);
    exp_code = 14'h0042; exp_mode = 2'b01; exp_upd++;
    check_state("R9 preload");
    send(16'hFFFF, 5);
    exp_code = RST_CODE; exp_mode = 2'b00; exp_upd++;
    check_state("R9 reset aborted at 5");
    send({2'b10, 14'h3001}, FW);
    exp_code = 14'h3001; exp_mode = 2'b10; exp_upd++;
    check_state("R9 preload 2");
    send(16'hFFFF, 2);
    exp_code = RST_CODE; exp_mode = 2'b00; exp_upd++;
    check_state("R9 reset aborted at 2");

    finish_run();
  end
endmodule